// File: doc/BRIEF.md
# Legacy I/O Positive Decode Unit

This block decides, for every I/O cycle presented to it, whether the cycle is claimed quickly by positive decode or left for a downstream ISA bridge to pick up by subtractive claiming. Eight fixed legacy port groups are covered: two floppy controller groups, four serial port windows, the keyboard controller pair and the real-time clock window. A ROM-space hit flag is also covered. Each group has its own enable bit. A set bit selects positive claiming and a clear bit selects subtractive claiming.

Two 8-bit decode-control registers hold these choices. They are written and read through a simple configuration port. The register select is `cfgSel`: 0 selects the group register and 1 selects the auxiliary register. An external keyboard lock input overrides the keyboard group bit. When an I/O strobe is accepted, the unit raises either `posClaim` one clock later or `subClaim` three clocks after the strobe. It never raises both.

Top module: `legacy_io_decoder`

## Requirements
- R1: After reset, the group register reads 0x01 and the auxiliary register reads 0x20. Only the clock group and the ROM select start out positive.
- R2: The auxiliary register stores bit 7 (alternate keyboard pair enable) and bit 5 (ROM positive select). Bit 6 and bits 4:0 always read 0, and writes to them have no effect.
- R3: Group bit 7 claims ports 0x372–0x375 and 0x377. Group bit 6 claims 0x3F2–0x3F5 and 0x3F7. Ports 0x376, 0x3F6, 0x370/0x371 and 0x3F0/0x3F1 are never claimed positively by these groups.
- R4: Group bits 2, 3, 4 and 5 claim the 8-port windows at 0x3F8, 0x2F8, 0x3E8 and 0x2E8, in that order.
- R5: Group bit 1 claims ports 0x060 and 0x064. Ports 0x062 and 0x066 join this group only while auxiliary bit 7 is 1.
- R6: Group bit 0 claims ports 0x070–0x073 and no neighbouring port.
- R7: When auxiliary bit 5 is 1, a cycle with the ROM hit flag set is claimed positively.
- R8: For an accepted strobe that matches an enabled group, `posClaim` is high for exactly the one clock after the strobe.
- R9: For an accepted strobe with no positive match, `subClaim` is high for exactly one clock, three clocks after the strobe.
- R10: At most one claim pulse is issued per I/O cycle, and no claim is issued without a strobe. A strobe that arrives while a subtractive claim is pending is ignored.
- R11: While `kbdLock` is high, group bit 1 reads 0 and keyboard ports are left subtractive. The stored bit is cleared, so it stays 0 after the lock is released.
- R12: A configuration write becomes effective from the next I/O cycle. A strobe on the same clock edge as the write is decoded with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSel | input | 1 | Register select: 0 group register, 1 auxiliary register |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data of the selected register |
| ioAddr | input | ADDR_W | I/O cycle address |
| ioStrobe | input | 1 | One-clock I/O cycle strobe |
| romHit | input | 1 | Cycle falls inside configured ROM space |
| kbdLock | input | 1 | Forces the keyboard group to subtractive |
| posClaim | output | 1 | Positive-claim pulse |
| subClaim | output | 1 | Subtractive-claim pulse |

## Verification
A wrong stored decode bit shows up at the ports in two ways. The next read of that register returns the wrong value. The next strobe to the affected group produces a `posClaim` one clock after the strobe where a `subClaim` was due two clocks later, or the reverse. A wrong delay counter state shows as a subtractive pulse on the wrong clock, a repeated pulse, or a later strobe that is wrongly accepted or dropped. All of these appear within four clocks of the strobe. The bench compares every clock against its reference model, so the first wrong cycle is reported.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

  // configuration write strobes from control to datapath
  typedef struct packed {
    logic wrGroup;
    logic wrAux;
  } cfgStrb_t;

  localparam logic [7:0] GROUP_RST = 8'h01;
  localparam logic [7:0] AUX_RST   = 8'h20;

  // bit positions inside the group register
  localparam int BIT_RTC  = 0;
  localparam int BIT_KBD  = 1;
  localparam int SER_LO   = 2;
  localparam int SER_N    = 4;
  localparam int FLP_LO   = 6;
  localparam int FLP_N    = 2;

  // bit positions inside the auxiliary register
  localparam int BIT_ROM  = 5;
  localparam int BIT_ALT  = 7;

  function automatic logic [15:0] serBase(input int idx);
    case (idx)
      0:       serBase = 16'h03F8;
      1:       serBase = 16'h02F8;
      2:       serBase = 16'h03E8;
      default: serBase = 16'h02E8;
    endcase
  endfunction

  function automatic logic [15:0] flpBase(input int idx);
    if (idx == 0) flpBase = 16'h03F0;
    else          flpBase = 16'h0370;
  endfunction

endpackage

// File: rtl/lpd_datapath.sv
module lpd_datapath
  import lpd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrb_t          strb,
  input  logic              cfgSel,
  input  logic [7:0]        cfgWrData,
  input  logic              kbdLock,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              romHit,
  output logic              posHit,
  output logic [7:0]        cfgRdData
);

  logic [7:0] groupReg;
  logic       altKbd;
  logic       romPos;
  logic [7:0] groupEff;
  logic [7:0] groupHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      groupReg <= GROUP_RST;
      altKbd   <= AUX_RST[BIT_ALT];
      romPos   <= AUX_RST[BIT_ROM];
    end else begin
      if (strb.wrGroup) groupReg <= cfgWrData;
      if (kbdLock) groupReg[BIT_KBD] <= 1'b0;
      if (strb.wrAux) begin
        altKbd <= cfgWrData[BIT_ALT];
        romPos <= cfgWrData[BIT_ROM];
      end
    end
  end

  always_comb begin
    groupEff = groupReg;
    groupEff[BIT_KBD] = groupReg[BIT_KBD] & ~kbdLock;
  end

  // serial windows: eight consecutive ports each
  for (genvar g = 0; g < SER_N; g++) begin : gSer
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(serBase(g));
    assign groupHit[SER_LO+g] = (ioAddr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
  end

  // floppy groups: offsets 2..5 and 7 of an eight-port block
  for (genvar f = 0; f < FLP_N; f++) begin : gFlp
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(flpBase(f));
    logic blockHit;
    logic offHit;
    assign blockHit = (ioAddr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);
    assign offHit   = (ioAddr[2:0] inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd7});
    assign groupHit[FLP_LO+f] = blockHit & offHit;
  end

  localparam logic [ADDR_W-1:0] KBD_DATA = ADDR_W'(16'h0060);
  localparam logic [ADDR_W-1:0] KBD_CMD  = ADDR_W'(16'h0064);
  localparam logic [ADDR_W-1:0] KBD_ALTD = ADDR_W'(16'h0062);
  localparam logic [ADDR_W-1:0] KBD_ALTC = ADDR_W'(16'h0066);
  localparam logic [ADDR_W-1:0] RTC_BASE = ADDR_W'(16'h0070);

  assign groupHit[BIT_KBD] = (ioAddr == KBD_DATA) || (ioAddr == KBD_CMD) ||
                             (altKbd && ((ioAddr == KBD_ALTD) || (ioAddr == KBD_ALTC)));
  assign groupHit[BIT_RTC] = (ioAddr[ADDR_W-1:2] == RTC_BASE[ADDR_W-1:2]);

  assign posHit = (|(groupHit & groupEff)) | (romHit & romPos);

  always_comb begin
    if (cfgSel) begin
      cfgRdData = 8'h00;
      cfgRdData[BIT_ALT] = altKbd;
      cfgRdData[BIT_ROM] = romPos;
    end else begin
      cfgRdData = groupEff;
    end
  end

endmodule

// File: rtl/lpd_ctrl.sv
module lpd_ctrl
  import lpd_pkg::*;
#(
  parameter int SUB_DELAY = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWrEn,
  input  logic     cfgSel,
  input  logic     ioStrobe,
  input  logic     posHit,
  output cfgStrb_t strb,
  output logic     posClaim,
  output logic     subClaim
);

  localparam int CNT_W = $clog2(SUB_DELAY + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SUB_DELAY - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] waitCnt;
  logic             busy;
  logic             accept;

  assign strb.wrGroup = cfgWrEn & ~cfgSel;
  assign strb.wrAux   = cfgWrEn & cfgSel;

  assign busy   = (waitCnt != '0);
  assign accept = ioStrobe & ~busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt  <= '0;
      posClaim <= 1'b0;
      subClaim <= 1'b0;
    end else begin
      posClaim <= accept & posHit;
      subClaim <= (waitCnt == ONE);
      if (busy)                  waitCnt <= waitCnt - ONE;
      else if (accept & ~posHit) waitCnt <= LOAD;
    end
  end

endmodule

// File: rtl/legacy_io_decoder.sv
module legacy_io_decoder
  import lpd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SUB_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSel,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioStrobe,
  input  logic              romHit,
  input  logic              kbdLock,
  output logic              posClaim,
  output logic              subClaim
);

  cfgStrb_t strb;
  logic     posHit;

  lpd_ctrl #(.SUB_DELAY(SUB_DELAY)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .ioStrobe (ioStrobe),
    .posHit   (posHit),
    .strb     (strb),
    .posClaim (posClaim),
    .subClaim (subClaim)
  );

  lpd_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .kbdLock   (kbdLock),
    .ioAddr    (ioAddr),
    .romHit    (romHit),
    .posHit    (posHit),
    .cfgRdData (cfgRdData)
  );

endmodule

// File: rtl/legacy_io_decoder_chk.sv
module legacy_io_decoder_chk #(
  parameter int ADDR_W    = 16,
  parameter int SUB_DELAY = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgSel,
  input logic              cfgWrEn,
  input logic [7:0]        cfgWrData,
  input logic [7:0]        cfgRdData,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioStrobe,
  input logic              romHit,
  input logic              kbdLock,
  input logic              posClaim,
  input logic              subClaim
);

  logic [SUB_DELAY-1:0] strobeHist;

  always_ff @(posedge clk) begin
    if (!rstN) strobeHist <= '0;
    else       strobeHist <= {strobeHist[SUB_DELAY-2:0], ioStrobe};
  end

  AST_CLAIM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(posClaim && subClaim)); // R10

  AST_POS_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    posClaim |-> strobeHist[0]); // R8

  AST_SUB_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    subClaim |-> strobeHist[SUB_DELAY-1]); // R9

  AST_SUB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    subClaim |=> !subClaim); // R9

  AST_AUX_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cfgSel |-> ((cfgRdData & 8'h5F) == 8'h00)); // R2

  AST_LOCK_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (kbdLock && !cfgSel) |-> !cfgRdData[1]); // R11

endmodule

bind legacy_io_decoder legacy_io_decoder_chk #(.ADDR_W(ADDR_W), .SUB_DELAY(SUB_DELAY)) u_chk (.*);

// File: tb/legacy_io_decoder_tb.sv
module legacy_io_decoder_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSel = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic [15:0] ioAddr = 16'h0000;
  logic        ioStrobe = 1'b0;
  logic        romHit = 1'b0;
  logic        kbdLock = 1'b0;
  logic        posClaim;
  logic        subClaim;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_io_decoder u_dut (
    .clk(clk), .rstN(rstN), .cfgSel(cfgSel), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .ioAddr(ioAddr),
    .ioStrobe(ioStrobe), .romHit(romHit), .kbdLock(kbdLock),
    .posClaim(posClaim), .subClaim(subClaim)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mGroup, mAlt, mRom, mPend;
  bit  mPos, mSub;

  function automatic bit inRange(int a, int lo, int hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic bit modelHit(int a, bit rom);
    int g;
    bit h;
    g = mGroup;
    if (kbdLock) g = g & 8'hFD;
    h = 0;
    if (g[7] && (inRange(a, 'h372, 'h375) || a == 'h377)) h = 1;
    if (g[6] && (inRange(a, 'h3F2, 'h3F5) || a == 'h3F7)) h = 1;
    if (g[5] && inRange(a, 'h2E8, 'h2EF)) h = 1;
    if (g[4] && inRange(a, 'h3E8, 'h3EF)) h = 1;
    if (g[3] && inRange(a, 'h2F8, 'h2FF)) h = 1;
    if (g[2] && inRange(a, 'h3F8, 'h3FF)) h = 1;
    if (g[1] && (a == 'h60 || a == 'h64 || (mAlt != 0 && (a == 'h62 || a == 'h66)))) h = 1;
    if (g[0] && inRange(a, 'h70, 'h73)) h = 1;
    if (mRom != 0 && rom) h = 1;
    return h;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mGroup = 'h01; mAlt = 1; mAlt = 0; mRom = 1; mPend = 0; mPos = 0; mSub = 0;
    end else begin
      bit hit;
      hit  = modelHit(int'(ioAddr), romHit);
      mSub = (mPend == 1);
      mPos = 0;
      if (mPend > 0) mPend--;
      else if (ioStrobe) begin
        if (hit) mPos = 1;
        else     mPend = 2;
      end
      if (cfgWrEn && !cfgSel) mGroup = int'(cfgWrData);
      if (cfgWrEn && cfgSel) begin
        mAlt = int'(cfgWrData[7]);
        mRom = int'(cfgWrData[5]);
      end
      if (kbdLock) mGroup = mGroup & 'hFD;
    end
  end

  // compare outputs on every clock, away from the edge
  always begin
    @(negedge clk);
    #1;
    if (rstN && !done) begin
      int expRd;
      if (cfgSel) expRd = (mAlt << 7) | (mRom << 5);
      else        expRd = kbdLock ? (mGroup & 'hFD) : mGroup;
      chk(posClaim === mPos, "R8 model posClaim", posClaim, mPos);
      chk(subClaim === mSub, "R9 model subClaim", subClaim, mSub);
      chk(cfgRdData === 8'(expRd), "R1 model cfgRdData", cfgRdData, expRd);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic cfgWrite(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfgSel = sel; cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input bit sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    cfgSel = sel;
    #2;
    chk(cfgRdData === exp, tag, cfgRdData, exp);
  endtask

  task automatic ioCycle(input logic [15:0] a, input bit rom, input bit expPos, input string tag);
    @(negedge clk);
    ioAddr = a; romHit = rom; ioStrobe = 1'b1;
    @(negedge clk);
    ioStrobe = 1'b0; romHit = 1'b0;
    #2;
    chk(posClaim === expPos, tag, posClaim, expPos);
    @(negedge clk);
    #2;
    chk(posClaim === 1'b0, "R8 pulse is one clock", posClaim, 0);
    @(negedge clk);
    #2;
    chk(subClaim === !expPos, tag, subClaim, !expPos);
    @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    cfgRead(0, 8'h01, "R1 group reset");
    cfgRead(1, 8'h20, "R1 aux reset");

    ioCycle(16'h0071, 0, 1, "R6 clock port 071");
    ioCycle(16'h0074, 0, 0, "R6 port 074 outside");
    ioCycle(16'h006F, 0, 0, "R6 port 06F outside");
    ioCycle(16'h03F8, 0, 0, "R4 serial off at reset");

    cfgWrite(0, 8'h3C);
    ioCycle(16'h02EF, 0, 1, "R4 bit5 2EF");
    ioCycle(16'h03EA, 0, 1, "R4 bit4 3EA");
    ioCycle(16'h02F8, 0, 1, "R4 bit3 2F8");
    ioCycle(16'h03FF, 0, 1, "R4 bit2 3FF");
    cfgWrite(0, 8'h04);
    ioCycle(16'h02E8, 0, 0, "R4 only bit2 set, 2E8");
    ioCycle(16'h03F8, 0, 1, "R4 only bit2 set, 3F8");

    cfgWrite(0, 8'hC0);
    ioCycle(16'h0372, 0, 1, "R3 secondary 372");
    ioCycle(16'h0377, 0, 1, "R3 secondary 377");
    ioCycle(16'h0376, 0, 0, "R3 376 excluded");
    ioCycle(16'h03F6, 0, 0, "R3 3F6 excluded");
    ioCycle(16'h03F4, 0, 1, "R3 primary 3F4");
    ioCycle(16'h03F1, 0, 0, "R3 3F1 excluded");
    ioCycle(16'h0378, 0, 0, "R3 378 outside");

    cfgWrite(0, 8'h02);
    ioCycle(16'h0060, 0, 1, "R5 kbd 060");
    ioCycle(16'h0064, 0, 1, "R5 kbd 064");
    ioCycle(16'h0062, 0, 0, "R5 062 without alt");
    cfgWrite(1, 8'hFF);
    cfgRead(1, 8'hA0, "R2 reserved bits read 0");
    ioCycle(16'h0066, 0, 1, "R5 066 with alt");
    ioCycle(16'h1234, 1, 1, "R7 rom hit positive");
    cfgWrite(1, 8'h00);
    cfgRead(1, 8'h00, "R2 aux cleared");
    ioCycle(16'h1234, 1, 0, "R7 rom select off");
    ioCycle(16'h0062, 0, 0, "R5 alt disabled again");

    @(negedge clk); kbdLock = 1'b1;
    cfgRead(0, 8'h00, "R11 locked bit reads 0");
    ioCycle(16'h0060, 0, 0, "R11 locked kbd subtractive");
    cfgWrite(0, 8'h03);
    cfgRead(0, 8'h01, "R11 write of bit1 blocked");
    @(negedge clk); kbdLock = 1'b0;
    cfgRead(0, 8'h01, "R11 bit stays cleared after lock");
    ioCycle(16'h0060, 0, 0, "R11 kbd still subtractive");

    // R12: write and strobe on the same edge use the old value
    cfgWrite(0, 8'h04);
    @(negedge clk);
    cfgSel = 1'b0; cfgWrEn = 1'b1; cfgWrData = 8'h00;
    ioAddr = 16'h03F8; ioStrobe = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0; ioStrobe = 1'b0;
    #2;
    chk(posClaim === 1'b1, "R12 same-edge strobe uses old value", posClaim, 1);
    repeat (3) @(negedge clk);
    ioCycle(16'h03F8, 0, 0, "R12 next cycle uses new value");

    // R10: strobe during pending subtractive claim is ignored
    cfgWrite(0, 8'h01);
    @(negedge clk);
    ioAddr = 16'h1234; ioStrobe = 1'b1;
    @(negedge clk);
    ioAddr = 16'h0071;
    #2;
    chk(posClaim === 1'b0, "R10 first cycle no pos", posClaim, 0);
    @(negedge clk);
    ioStrobe = 1'b0;
    #2;
    chk(posClaim === 1'b0, "R10 busy strobe ignored", posClaim, 0);
    @(negedge clk);
    #2;
    chk(subClaim === 1'b1, "R10 pending sub delivered", subClaim, 1);
    @(negedge clk);
    #2;
    chk((posClaim | subClaim) === 1'b0, "R10 no claim for ignored strobe", {posClaim, subClaim}, 0);
    repeat (4) begin
      @(negedge clk);
      #2;
      chk((posClaim | subClaim) === 1'b0, "R10 idle no claim", {posClaim, subClaim}, 0);
    end

    finishRun();
  end

  initial begin
    wait (cycles > 50000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 50000);
      finishRun();
    end
  end

endmodule